// File: doc/BRIEF.md
# Ethernet Transmit Status Word Generator

This block follows one frame transmission of a 10/100 Ethernet MAC and builds the 12-bit transmit status field that is written back into the frame's descriptor. The transmitter feeds it single-cycle event pulses: frame start and frame end, collisions (each tagged with the bit time elapsed since the frame began), deferral, excessive deferral, FIFO underflow, heartbeat detection, a missing next descriptor and a stopped transmit process. It also watches the carrier sense level.

Each collision is counted against a retry limit taken from a configuration input. After each collision the block pulses either a retry request, so the external backoff logic can restart the frame, or an abort. A collision seen after the late-collision threshold always aborts. When the frame ends normally or is aborted, the block presents the finished status word together with a one-cycle valid strobe. The word then stays unchanged until the next frame completes. All per-frame state is cleared by the frame-start pulse.

Top module: `txstat_gen`

## Requirements
- R1: While reset is high and in the first cycle after reset, `stat_valid_o`, `retry_o`, `abort_o` and `suspend_o` are 0 and `stat_word_o` is all zeros.
- R2: Status bit layout: 11 deferred, 10 single collision, 9 multiple collisions, 8 excessive-collision abort, 7 late collision, 6 carrier lost, 5 heartbeat missed, 4 underflow, 3 always 0, 2 no descriptor, 1 process stopped, 0 good frame. Events are sampled only while a frame is open, which is from the cycle after `frm_start` until it ends or aborts.
- R3: Bit 10 is set only for a frame that ends normally after exactly one collision.
- R4: Bit 9 is set only for a frame that ends normally after two or more collisions.
- R5: A non-late collision that brings the count above `cfg_retry_limit` aborts the frame. One cycle later `abort_o` pulses and the word is issued with bit 8 set.
- R6: A collision whose `col_bit_time` is greater than 512 aborts the frame whatever the count is. The word is issued with bit 7 set and no retry pulse is given.
- R7: A non-late collision that keeps the count within the limit gives a one-cycle `retry_o` pulse in the next cycle and does not end the frame.
- R8: Bit 6 is set if `crs` is sampled low in any cycle of the open frame.
- R9: Bit 5 is set when no `sqe_seen` pulse occurs while the frame is open, including its final cycle.
- R10: An underflow sets bit 4 and raises `suspend_o` from the next cycle until the next `frm_start`.
- R11: Bit 0 is set on a normal end unless an underflow, excessive deferral, late collision or excessive collision occurred. Deferral, single collision, multiple collisions and missed heartbeat do not affect it. It is never set on an abort.
- R12: Bit 11 reports a deferral only when `cfg_full_duplex` is 0. In full-duplex mode it is 0.
- R13: `stat_valid_o` is high for exactly one cycle, the cycle after the end or abort. The word holds until the next completion. `frm_start` clears all per-frame state, and events outside an open frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full_duplex | input | 1 | 1 selects full-duplex operation |
| cfg_retry_limit | input | RETRY_W | Number of collisions allowed before abort |
| frm_start | input | 1 | Pulse: a new frame begins |
| frm_end | input | 1 | Pulse: the frame finished transmitting |
| col_evt | input | 1 | Pulse: collision detected |
| col_bit_time | input | BT_W | Bit times since frame start at the collision |
| crs | input | 1 | Carrier sense level |
| defer_evt | input | 1 | Pulse: transmission deferred |
| exdefer_evt | input | 1 | Pulse: excessive deferral |
| underflow_evt | input | 1 | Pulse: transmit FIFO underflow |
| sqe_seen | input | 1 | Pulse: heartbeat seen on the collision line |
| nobuf_evt | input | 1 | Pulse: next descriptor not available |
| stopped_evt | input | 1 | Pulse: transmit process stopped |
| retry_o | output | 1 | Pulse: restart the frame after backoff |
| abort_o | output | 1 | Pulse: frame aborted by a collision |
| suspend_o | output | 1 | Transmit suspended by underflow |
| stat_valid_o | output | 1 | One-cycle strobe: status word is ready |
| stat_word_o | output | 12 | Transmit status word |

## Verification
The hardest case to reach is a collision landing exactly on a boundary. It can arrive at bit time 512 or 513, or as the collision that reaches the limit or goes one past it. The same cycle may also carry the frame end or the heartbeat. Directed frames set the limit to 3 and place collisions at exactly those points, including a collision in the same cycle as `frm_end`. Seeded random frames then mix collisions, carrier drops and late bit times with random limits and both duplex modes. They also keep driving events after an abort, to confirm that a closed frame ignores them.

// File: rtl/txstat_pkg.sv
`timescale 1ns/1ps
package txstat_pkg;

    localparam int STAT_W  = 12;
    localparam int B_DEF   = 11;
    localparam int B_SCOL  = 10;
    localparam int B_MCOL  = 9;
    localparam int B_EXCOL = 8;
    localparam int B_LCOL  = 7;
    localparam int B_LCAR  = 6;
    localparam int B_SQE   = 5;
    localparam int B_UNF   = 4;
    localparam int B_RSV   = 3;
    localparam int B_NOBUF = 2;
    localparam int B_STOP  = 1;
    localparam int B_GOOD  = 0;

    // sticky per-frame observations gathered from the transmitter
    typedef struct packed {
        logic deferred;
        logic exdefer;
        logic lost_carrier;
        logic sqe_seen;
        logic underflow;
        logic no_buffer;
        logic stopped;
    } evflags_t;

    // collision classification for one frame
    typedef struct packed {
        logic one_col;
        logic many_col;
        logic late;
        logic excess;
    } colsum_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input evflags_t f,
        input colsum_t  c,
        input logic     normal,
        input logic     fdx
    );
        logic [STAT_W-1:0] w;
        w          = '0;
        w[B_DEF]   = f.deferred & ~fdx;
        w[B_SCOL]  = normal & c.one_col;
        w[B_MCOL]  = normal & c.many_col;
        w[B_EXCOL] = c.excess;
        w[B_LCOL]  = c.late;
        w[B_LCAR]  = f.lost_carrier;
        w[B_SQE]   = ~f.sqe_seen;
        w[B_UNF]   = f.underflow;
        w[B_RSV]   = 1'b0;
        w[B_NOBUF] = f.no_buffer;
        w[B_STOP]  = f.stopped;
        w[B_GOOD]  = normal & ~f.underflow & ~f.exdefer & ~c.late & ~c.excess;
        return w;
    endfunction

endpackage

// File: rtl/txstat_coll.sv
`timescale 1ns/1ps
module txstat_coll
    import txstat_pkg::*;
#(
    parameter int RETRY_W = 4,
    parameter int BT_W    = 11,
    parameter int LATE_BT = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_start,
    input  logic               active,
    input  logic               col_evt,
    input  logic [BT_W-1:0]    col_bit_time,
    input  logic [RETRY_W-1:0] retry_limit,
    output colsum_t            sum_nx,
    output logic               abort_now,
    output logic               retry_o,
    output logic               abort_o
);
    localparam int CNT_W = RETRY_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [BT_W-1:0]  LATE_LIM = BT_W'(LATE_BT);

    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             late_q, late_nx, exc_q, exc_nx;
    logic             hit, retry_now;

    always_comb begin
        hit       = active & col_evt & ~frm_start;
        cnt_nx    = cnt_q;
        late_nx   = late_q;
        exc_nx    = exc_q;
        abort_now = 1'b0;
        retry_now = 1'b0;
        if (hit) begin
            if (cnt_q != CNT_MAX) cnt_nx = cnt_q + 1'b1;
            if (col_bit_time > LATE_LIM) begin
                late_nx   = 1'b1;
                abort_now = 1'b1;
            end else if (cnt_nx > {1'b0, retry_limit}) begin
                exc_nx    = 1'b1;
                abort_now = 1'b1;
            end else begin
                retry_now = 1'b1;
            end
        end
    end

    always_comb begin
        sum_nx.one_col  = (cnt_nx == CNT_W'(1));
        sum_nx.many_col = (cnt_nx > CNT_W'(1));
        sum_nx.late     = late_nx;
        sum_nx.excess   = exc_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || frm_start) begin
            cnt_q   <= '0;
            late_q  <= 1'b0;
            exc_q   <= 1'b0;
            retry_o <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            cnt_q   <= cnt_nx;
            late_q  <= late_nx;
            exc_q   <= exc_nx;
            retry_o <= retry_now;
            abort_o <= abort_now;
        end
    end
endmodule

// File: rtl/txstat_flags.sv
`timescale 1ns/1ps
module txstat_flags
    import txstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frm_start,
    input  logic     frm_end,
    input  logic     abort_now,
    input  logic     crs,
    input  logic     defer_evt,
    input  logic     exdefer_evt,
    input  logic     underflow_evt,
    input  logic     sqe_seen,
    input  logic     nobuf_evt,
    input  logic     stopped_evt,
    output logic     active,
    output evflags_t flags_nx,
    output logic     done_now,
    output logic     normal_now,
    output logic     suspend_o
);
    evflags_t flags_q;
    logic     live;

    always_comb begin
        live     = active & ~frm_start;
        flags_nx = flags_q;
        if (live) begin
            flags_nx.deferred     = flags_q.deferred     | defer_evt;
            flags_nx.exdefer      = flags_q.exdefer      | exdefer_evt;
            flags_nx.lost_carrier = flags_q.lost_carrier | ~crs;
            flags_nx.sqe_seen     = flags_q.sqe_seen     | sqe_seen;
            flags_nx.underflow    = flags_q.underflow    | underflow_evt;
            flags_nx.no_buffer    = flags_q.no_buffer    | nobuf_evt;
            flags_nx.stopped      = flags_q.stopped      | stopped_evt;
        end
        done_now   = live & (frm_end | abort_now);
        normal_now = live & frm_end & ~abort_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            flags_q <= '0;
        end else if (frm_start) begin
            active  <= 1'b1;
            flags_q <= '0;
        end else begin
            active  <= active & ~done_now;
            flags_q <= flags_nx;
        end
    end

    assign suspend_o = flags_q.underflow;
endmodule

// File: rtl/txstat_pack.sv
`timescale 1ns/1ps
module txstat_pack
    import txstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_now,
    input  logic              normal_now,
    input  evflags_t          flags_nx,
    input  colsum_t           sum_nx,
    input  logic              fdx,
    output logic              stat_valid_o,
    output logic [STAT_W-1:0] stat_word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid_o <= 1'b0;
            stat_word_o  <= '0;
        end else begin
            stat_valid_o <= done_now;
            if (done_now)
                stat_word_o <= pack_status(flags_nx, sum_nx, normal_now, fdx);
        end
    end
endmodule

// File: rtl/txstat_gen.sv
`timescale 1ns/1ps
module txstat_gen
    import txstat_pkg::*;
#(
    parameter int RETRY_W = 4,
    parameter int BT_W    = 11,
    parameter int LATE_BT = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_full_duplex,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    input  logic               frm_start,
    input  logic               frm_end,
    input  logic               col_evt,
    input  logic [BT_W-1:0]    col_bit_time,
    input  logic               crs,
    input  logic               defer_evt,
    input  logic               exdefer_evt,
    input  logic               underflow_evt,
    input  logic               sqe_seen,
    input  logic               nobuf_evt,
    input  logic               stopped_evt,
    output logic               retry_o,
    output logic               abort_o,
    output logic               suspend_o,
    output logic               stat_valid_o,
    output logic [11:0]        stat_word_o
);
    logic     active, abort_now, done_now, normal_now;
    colsum_t  sum_nx;
    evflags_t flags_nx;

    txstat_coll #(.RETRY_W(RETRY_W), .BT_W(BT_W), .LATE_BT(LATE_BT)) u_coll (
        .clk(clk), .rst(rst), .frm_start(frm_start), .active(active),
        .col_evt(col_evt), .col_bit_time(col_bit_time),
        .retry_limit(cfg_retry_limit), .sum_nx(sum_nx),
        .abort_now(abort_now), .retry_o(retry_o), .abort_o(abort_o)
    );

    txstat_flags u_flags (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
        .abort_now(abort_now), .crs(crs), .defer_evt(defer_evt),
        .exdefer_evt(exdefer_evt), .underflow_evt(underflow_evt),
        .sqe_seen(sqe_seen), .nobuf_evt(nobuf_evt), .stopped_evt(stopped_evt),
        .active(active), .flags_nx(flags_nx), .done_now(done_now),
        .normal_now(normal_now), .suspend_o(suspend_o)
    );

    txstat_pack u_pack (
        .clk(clk), .rst(rst), .done_now(done_now), .normal_now(normal_now),
        .flags_nx(flags_nx), .sum_nx(sum_nx), .fdx(cfg_full_duplex),
        .stat_valid_o(stat_valid_o), .stat_word_o(stat_word_o)
    );
endmodule

// File: rtl/txstat_chk.sv
`timescale 1ns/1ps
module txstat_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_full_duplex,
    input logic        frm_start,
    input logic        retry_o,
    input logic        abort_o,
    input logic        suspend_o,
    input logic        stat_valid_o,
    input logic [11:0] stat_word_o
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        stat_valid_o |-> !stat_word_o[3]);

    a_r3_r4_col_exclusive: assert property (@(posedge clk) disable iff (rst)
        stat_valid_o |-> $onehot0({stat_word_o[10], stat_word_o[9]}));

    a_r5_r6_abort_issues_word: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> stat_valid_o);

    a_r7_retry_not_abort: assert property (@(posedge clk) disable iff (rst)
        !(retry_o && abort_o));

    a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (suspend_o && !frm_start) |=> suspend_o);

    a_r11_good_masked: assert property (@(posedge clk) disable iff (rst)
        (stat_valid_o && stat_word_o[0]) |->
            (!stat_word_o[4] && !stat_word_o[7] && !stat_word_o[8]));

    a_r12_fdx_no_defer: assert property (@(posedge clk) disable iff (rst)
        (stat_valid_o && $past(cfg_full_duplex)) |-> !stat_word_o[11]);

    a_r13_single_strobe: assert property (@(posedge clk) disable iff (rst)
        stat_valid_o |=> !stat_valid_o);

    a_r13_word_held: assert property (@(posedge clk) disable iff (rst)
        !stat_valid_o |-> $stable(stat_word_o));
endmodule

bind txstat_gen txstat_chk u_chk (
    .clk(clk), .rst(rst), .cfg_full_duplex(cfg_full_duplex),
    .frm_start(frm_start), .retry_o(retry_o), .abort_o(abort_o),
    .suspend_o(suspend_o), .stat_valid_o(stat_valid_o),
    .stat_word_o(stat_word_o)
);

// File: tb/txstat_gen_tb.sv
`timescale 1ns/1ps
module txstat_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fdx = 1'b0;
    logic [3:0]  lim = 4'd3;
    logic        s = 0, e = 0, col = 0, crs = 1, dfr = 0, exd = 0, unf = 0;
    logic        sqe = 0, nb = 0, st = 0;
    logic [10:0] bt = '0;
    logic        retry_o, abort_o, suspend_o, stat_valid_o;
    logic [11:0] stat_word_o;

    int    n_chk = 0, n_bad = 0;
    string req = "R1";
    bit    finished = 0;

    // reference model state
    bit       m_act, m_def, m_exd, m_lcar, m_sqe, m_unf, m_nb, m_st, m_late, m_exc;
    int       m_cnt;
    bit [11:0] m_word;

    always #2.5 clk = ~clk;

    txstat_gen u_dut (
        .clk(clk), .rst(rst), .cfg_full_duplex(fdx), .cfg_retry_limit(lim),
        .frm_start(s), .frm_end(e), .col_evt(col), .col_bit_time(bt),
        .crs(crs), .defer_evt(dfr), .exdefer_evt(exd), .underflow_evt(unf),
        .sqe_seen(sqe), .nobuf_evt(nb), .stopped_evt(st),
        .retry_o(retry_o), .abort_o(abort_o), .suspend_o(suspend_o),
        .stat_valid_o(stat_valid_o), .stat_word_o(stat_word_o)
    );

    function automatic bit [11:0] mk_word(input bit normal);
        bit [11:0] w = '0;
        w[11] = m_def && !fdx;
        w[10] = normal && m_cnt == 1;
        w[9]  = normal && m_cnt > 1;
        w[8]  = m_exc;
        w[7]  = m_late;
        w[6]  = m_lcar;
        w[5]  = !m_sqe;
        w[4]  = m_unf;
        w[2]  = m_nb;
        w[1]  = m_st;
        w[0]  = normal && !m_unf && !m_exd && !m_late && !m_exc;
        return w;
    endfunction

    task automatic check(input bit [15:0] act, input bit [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {retry,abort,suspend,valid,word} actual=%h expected=%h",
                     req, act, exp);
        end
    endtask

    // one clock cycle: inputs already set; model predicts, then compare after edge
    task automatic cyc();
        bit er = 0, ea = 0, ev = 0, ab = 0;
        if (s) begin
            m_act = 1; m_def = 0; m_exd = 0; m_lcar = 0; m_sqe = 0; m_unf = 0;
            m_nb = 0; m_st = 0; m_late = 0; m_exc = 0; m_cnt = 0;
        end else if (m_act) begin
            m_def |= dfr; m_exd |= exd; m_lcar |= !crs; m_sqe |= sqe;
            m_unf |= unf; m_nb |= nb; m_st |= st;
            if (col) begin
                if (m_cnt < 31) m_cnt++;
                if (bt > 512) begin m_late = 1; ab = 1; end
                else if (m_cnt > lim) begin m_exc = 1; ab = 1; end
                else er = 1;
            end
            ea = ab;
            if (ab || e) begin
                m_word = mk_word(e && !ab);
                ev = 1;
                m_act = 0;
            end
        end
        @(posedge clk);
        #1;
        check({retry_o, abort_o, suspend_o, stat_valid_o, stat_word_o},
              {er, ea, m_unf, ev, m_word});
        s = 0; e = 0; col = 0; crs = 1; dfr = 0; exd = 0; unf = 0;
        sqe = 0; nb = 0; st = 0; bt = '0;
    endtask

    task automatic start();  s = 1; cyc(); endtask
    task automatic idle();   cyc(); endtask
    task automatic collide(input int t); col = 1; bt = 11'(t); cyc(); endtask
    task automatic finish_frm(input bit hb); e = 1; sqe = hb; cyc(); endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        req = "R1";
        check({retry_o, abort_o, suspend_o, stat_valid_o, stat_word_o}, 16'h0);
        rst = 0;
        m_word = '0; m_act = 0; m_unf = 0;
        idle();

        // R3: one collision then normal end with heartbeat -> single + good
        req = "R3"; start(); collide(100); idle(); finish_frm(1); idle();
        // R4: two collisions -> multiple
        req = "R4"; start(); collide(60); collide(70); finish_frm(1); idle();
        // R7: count reaches limit (3) -> still retried
        req = "R7"; start(); collide(10); collide(20); collide(30); finish_frm(1); idle();
        // R5: fourth collision exceeds limit -> abort, excessive bit
        req = "R5"; start(); collide(10); collide(20); collide(30); collide(40);
        req = "R13"; e = 1; idle(); col = 1; idle(); idle();
        // R6: bit time 512 is not late, 513 is late
        req = "R6"; start(); collide(512); collide(513); idle();
        // R6: late collision with count already past nothing else
        req = "R6"; start(); collide(2000); idle();
        // R3 collision on same cycle as end
        req = "R3"; start(); col = 1; bt = 11'd5; e = 1; sqe = 1; cyc(); idle();
        // R8: carrier drop
        req = "R8"; start(); crs = 0; idle(); finish_frm(1); idle();
        // R9: heartbeat missing
        req = "R9"; start(); idle(); finish_frm(0); idle();
        // R10: underflow suspends until next start
        req = "R10"; start(); unf = 1; idle(); idle(); finish_frm(1); idle(); idle();
        req = "R10"; start(); idle(); finish_frm(1);
        // R11: excessive deferral blocks good, deferral does not
        req = "R11"; start(); exd = 1; idle(); finish_frm(1); idle();
        req = "R11"; start(); dfr = 1; idle(); finish_frm(0); idle();
        // R12: deferral in full duplex reads zero
        req = "R12"; fdx = 1; start(); dfr = 1; idle(); finish_frm(1); idle(); fdx = 0;
        // R2: no-buffer, stopped, and events outside a frame
        req = "R2"; start(); nb = 1; idle(); st = 1; finish_frm(1);
        req = "R13"; unf = 1; dfr = 1; crs = 0; idle(); e = 1; idle();
        // R13: restart mid-frame clears state
        req = "R13"; start(); crs = 0; unf = 1; idle(); start(); finish_frm(1); idle();

        // random frames
        req = "R2";
        void'($urandom(32'd20240611));
        for (int f = 0; f < 400; f++) begin
            lim = 4'($urandom_range(0, 15));
            fdx = 1'($urandom_range(0, 1));
            start();
            for (int c = 0; c < $urandom_range(1, 24); c++) begin
                col = ($urandom_range(0, 5) == 0);
                bt  = ($urandom_range(0, 7) == 0) ? 11'($urandom_range(480, 600))
                                                  : 11'($urandom_range(0, 511));
                crs = ($urandom_range(0, 30) != 0);
                dfr = ($urandom_range(0, 15) == 0);
                exd = ($urandom_range(0, 40) == 0);
                unf = ($urandom_range(0, 40) == 0);
                sqe = ($urandom_range(0, 8) == 0);
                nb  = ($urandom_range(0, 40) == 0);
                st  = ($urandom_range(0, 40) == 0);
                cyc();
            end
            e = 1; sqe = 1'($urandom_range(0, 1)); cyc();
            if ($urandom_range(0, 1) == 1) idle();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule